// File: doc/BRIEF.md
# SIMD Signed Widening Add Unit

This block decodes one 32-bit vector instruction word and, when the word names the signed widening add, adds each narrow signed element taken from one half of a second 128-bit source to the matching element of a 128-bit first source. Each first-source element is twice as wide as a narrow element. Before the add, the narrow element is sign-extended to the wide width. Each sum keeps only the wide width, so overflow wraps and raises no flag. The second source gives either its low 64 bits or its high 64 bits. The half is picked by a select bit in the word. A two-bit size field sets the narrow element width to 8, 16 or 32 bits.

Words enter on a valid/ready input stream and leave on a valid/ready output stream through a single output register. A word is taken when `in_valid` and `in_ready` are both high at a clock edge. Its outcome appears on the next cycle and stays unchanged until the consumer raises `out_ready`. The input is ready whenever the output register is empty or is being drained in the same cycle. So back-pressure costs no bubble while the consumer keeps `out_ready` high. A word that fails decode is flagged as undefined. When vector execution is disabled, a valid word is flagged as trapped. In both cases the result is forced to zero. The register indices from the word travel with the result.

Top module: `simd_wadd_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0, so `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, every output holds its value.
- R3: A word accepted at a clock edge produces `out_valid` = 1 from that edge onward, carrying that word's outcome. Outcomes leave in acceptance order.
- R4: A word matches only when bit 31 = 0, bits 29:24 = 001110, bit 21 = 1 and bits 15:10 = 000100. Any other word sets `out_undef` = 1 with `out_result` = 0.
- R5: A matching word with size field bits 23:22 = 11 sets `out_undef` = 1 with `out_result` = 0.
- R6: `out_rd`, `out_rn` and `out_rm` carry word bits 4:0, 9:5 and 20:16, whatever the decode outcome.
- R7: Select bit 30 = 0 takes the narrow elements from bits 63:0 of `in_opb`. Bit 30 = 1 takes them from bits 127:64.
- R8: Size 00, 01 or 10 gives narrow width N = 8, 16 or 32 and 64/N lanes. Result lane i (width 2N, at bit offset 2N·i) is the low 2N bits of `in_opa` lane i plus sign-extended narrow element i (width N, at bit offset N·i of the selected half).
- R9: With `simd_en` = 0, a word that decodes cleanly sets `out_trap` = 1, `out_undef` = 0 and `out_result` = 0. An undefined word still reports `out_undef` and not `out_trap`.
- R10: `out_undef` and `out_trap` are never both 1. Both are 0 for a clean, enabled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_insn | input | 32 | Instruction word |
| in_opa | input | 128 | First source, wide lanes |
| in_opb | input | 128 | Second source, half selected by the word |
| simd_en | input | 1 | 1 = vector execution permitted, 0 = trap |
| out_valid | output | 1 | Outcome present |
| out_ready | input | 1 | Consumer takes the outcome this cycle |
| out_result | output | 128 | Wide-lane sums, zero on undefined or trap |
| out_rd | output | 5 | Destination index |
| out_rn | output | 5 | First source index |
| out_rm | output | 5 | Second source index |
| out_undef | output | 1 | Word is not a defined form of this operation |
| out_trap | output | 1 | Operation blocked by `simd_en` |

## Verification
The bench fills every lane with the most positive and the most negative narrow and wide values at each size. A design that zero-extends, or that carries across lane boundaries, would return wrong high halves or corrupt the neighbouring lanes. It runs both select-bit values over patterns whose halves differ, which exposes a swapped or fixed half. It also sends the reserved size, single-bit opcode corruptions and disabled execution, which catch a missing undefined check or a trap/undefined priority that is inverted. Random stalls on `out_ready` check that a held outcome neither changes nor is lost or duplicated.

// File: rtl/swadd_pkg.sv
package swadd_pkg;
  localparam int INSN_W = 32;
  localparam int VEC_W  = 128;
  localparam int HALF_W = VEC_W / 2;
  localparam int IDX_W  = 5;
  localparam int SZ_W   = 2;
  localparam int NUM_SZ = 3;          // legal size codes 0..2
  localparam int BASE_W = 8;          // narrow width at size code 0

  typedef struct packed {
    logic             match;
    logic             sel_hi;
    logic [SZ_W-1:0]  size;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rm;
  } dec_t;
endpackage

// File: rtl/swadd_decode.sv
module swadd_decode
  import swadd_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  always_comb begin
    dec.match  = (insn[31] == 1'b0) && (insn[29:24] == 6'b001110) &&
                 (insn[21] == 1'b1) && (insn[15:10] == 6'b000100);
    dec.sel_hi = insn[30];
    dec.size   = insn[23:22];
    dec.rm     = insn[20:16];
    dec.rn     = insn[9:5];
    dec.rd     = insn[4:0];
  end
endmodule

// File: rtl/swadd_lanes.sv
module swadd_lanes
  import swadd_pkg::*;
(
  input  logic [VEC_W-1:0]  wide,
  input  logic [HALF_W-1:0] narrow,
  input  logic [SZ_W-1:0]   size,
  output logic [VEC_W-1:0]  sum
);
  logic [VEC_W-1:0] per_sz [NUM_SZ];

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
    localparam int NW    = BASE_W << s;
    localparam int WW    = 2 * NW;
    localparam int LANES = HALF_W / NW;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [NW-1:0] nel;
      assign nel = narrow[NW*l +: NW];
      assign per_sz[s][WW*l +: WW] = wide[WW*l +: WW] + {{NW{nel[NW-1]}}, nel};
    end
  end

  always_comb begin
    unique case (size)
      2'd0:    sum = per_sz[0];
      2'd1:    sum = per_sz[1];
      2'd2:    sum = per_sz[2];
      default: sum = '0;
    endcase
  end
endmodule

// File: rtl/simd_wadd_unit.sv
module simd_wadd_unit
  import swadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [VEC_W-1:0]  in_opa,
  input  logic [VEC_W-1:0]  in_opb,
  input  logic              simd_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_result,
  output logic [IDX_W-1:0]  out_rd,
  output logic [IDX_W-1:0]  out_rn,
  output logic [IDX_W-1:0]  out_rm,
  output logic              out_undef,
  output logic              out_trap
);
  dec_t              dec;
  logic [HALF_W-1:0] narrow;
  logic [VEC_W-1:0]  lane_sum;
  logic              undef_c, trap_c;

  swadd_decode u_dec (.insn(in_insn), .dec(dec));

  assign narrow = dec.sel_hi ? in_opb[VEC_W-1:HALF_W] : in_opb[HALF_W-1:0];

  swadd_lanes u_lanes (.wide(in_opa), .narrow(narrow), .size(dec.size), .sum(lane_sum));

  // decode failure wins over the enable check
  assign undef_c  = !dec.match || (dec.size == 2'b11);
  assign trap_c   = !undef_c && !simd_en;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_rd     <= '0;
      out_rn     <= '0;
      out_rm     <= '0;
      out_undef  <= 1'b0;
      out_trap   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= (undef_c || trap_c) ? '0 : lane_sum;
        out_rd     <= dec.rd;
        out_rn     <= dec.rn;
        out_rm     <= dec.rm;
        out_undef  <= undef_c;
        out_trap   <= trap_c;
      end
    end
  end
endmodule

// File: rtl/swadd_checker.sv
module swadd_checker
  import swadd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [INSN_W-1:0] in_insn,
  input logic              simd_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VEC_W-1:0]  out_result,
  input logic [IDX_W-1:0]  out_rd,
  input logic              out_undef,
  input logic              out_trap
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid); // R2
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_result) && $stable(out_rd) && $stable(out_undef) && $stable(out_trap)); // R2
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R3
  AST_IDX_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_rd == $past(in_insn[4:0])); // R6
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_undef || out_trap) |-> out_result == '0); // R4
  AST_RESERVED_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_insn[23:22] == 2'b11 |=> out_undef); // R5
  AST_DISABLED_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !simd_en |=> out_undef || out_trap); // R9
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_undef && out_trap)); // R10
endmodule

bind simd_wadd_unit swadd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_insn(in_insn), .simd_en(simd_en), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_rd(out_rd),
  .out_undef(out_undef), .out_trap(out_trap)
);

// File: tb/sim_simd_wadd_unit.sv
`timescale 1ns/1ps
module sim_simd_wadd_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, simd_en = 1'b1, out_valid, out_ready = 1'b0;
  logic [31:0] in_insn = '0;
  logic [127:0] in_opa = '0, in_opb = '0, out_result;
  logic [4:0] out_rd, out_rn, out_rm;
  logic out_undef, out_trap;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [127:0] q_res[$];
  logic [14:0]  q_idx[$];
  logic [1:0]   q_flg[$];

  always #2 clk = ~clk;

  simd_wadd_unit u0 (.*);

  function automatic logic [31:0] mk(input bit q, input logic [1:0] sz,
                                     input logic [4:0] rm, rn, rd);
    return {1'b0, q, 6'b001110, sz, 1'b1, rm, 6'b000100, rn, rd};
  endfunction

  function automatic logic [127:0] ref_sum(input logic [127:0] a, b,
                                          input bit q, input int sz);
    logic [127:0] r = '0;
    logic [63:0] half = q ? b[127:64] : b[63:0];
    int nw = 8 << sz;
    logic [63:0] nmask = (64'd1 << nw) - 1;
    logic [63:0] wmask = (nw == 32) ? '1 : ((64'd1 << (2*nw)) - 1);
    for (int l = 0; l < 64/nw; l++) begin
      logic [63:0] n = (half >> (nw*l)) & nmask;
      logic [63:0] w = 64'(a >> (2*nw*l)) & wmask;
      if (n[nw-1]) n = n | ~nmask;
      r = r | (128'((w + n) & wmask) << (2*nw*l));
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, score transfer, push expectation
  task automatic step(input bit v, input logic [31:0] w,
                      input logic [127:0] a, b, input bit en, input bit rdy);
    @(negedge clk);
    in_valid = v; in_insn = w; in_opa = a; in_opb = b; simd_en = en; out_ready = rdy;
    #1;
    chk(in_ready == (!out_valid || out_ready), "R2", 128'(in_ready), 128'(!out_valid || out_ready));
    chk(out_valid == (q_res.size() != 0), "R3", 128'(out_valid), 128'(q_res.size() != 0));
    if (out_valid && out_ready && q_res.size() != 0) begin
      logic [127:0] er = q_res.pop_front();
      logic [14:0]  ei = q_idx.pop_front();
      logic [1:0]   ef = q_flg.pop_front();
      chk(out_result == er, "R8 R7", out_result, er);
      chk({out_rm, out_rn, out_rd} == ei, "R6", 128'({out_rm, out_rn, out_rd}), 128'(ei));
      chk({out_undef, out_trap} == ef, "R4/R5/R9", 128'({out_undef, out_trap}), 128'(ef));
      chk(!(out_undef && out_trap), "R10", 128'({out_undef, out_trap}), 128'(0));
    end
    if (v && in_ready) begin
      bit match = (w[31] == 0) && (w[29:24] == 6'b001110) && w[21] && (w[15:10] == 6'b000100);
      bit und = !match || (w[23:22] == 2'b11);
      bit trp = !und && !en;
      q_res.push_back((und || trp) ? '0 : ref_sum(a, b, w[30], int'(w[23:22])));
      q_idx.push_back({w[20:16], w[9:5], w[4:0]});
      q_flg.push_back({und, trp});
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) step(0, '0, '0, '0, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0 && in_ready == 1, "R1", 128'({out_valid, in_ready}), 128'(1));
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(out_valid == 0, "R1", 128'(out_valid), 128'(0));

    // R8: lane extremes at each size, both halves (R7)
    for (int sz = 0; sz < 3; sz++)
      for (int q = 0; q < 2; q++) begin
        logic [127:0] pmax = '0, nmin = '0, wmax = '0, wmin = '0;
        int nw = 8 << sz;
        for (int l = 0; l < 64/nw; l++) begin
          pmax[nw*l +: 8] = 8'hFF; nmin = nmin | (128'(1) << (nw*l + nw - 1));
        end
        for (int l = 0; l < 64/nw; l++) begin
          pmax = pmax | (((128'(1) << (nw-1)) - 1) << (nw*l));
          wmax = wmax | (((128'(1) << (2*nw-1)) - 1) << (2*nw*l));
          wmin = wmin | (128'(1) << (2*nw*l + 2*nw - 1));
        end
        pmax = pmax & ~nmin;
        step(1, mk(q, 2'(sz), 5'd3, 5'd7, 5'd31), wmax, {pmax, pmax}, 1, 1);
        step(1, mk(q, 2'(sz), 5'd1, 5'd2, 5'd0), wmin, {nmin, nmin}, 1, 1);
        step(1, mk(q, 2'(sz), 5'd9, 5'd8, 5'd4), wmax, q ? {nmin, pmax} : {pmax, nmin}, 1, 1);
        step(1, mk(q, 2'(sz), 5'd5, 5'd6, 5'd7), '1, {64'h0123456789ABCDEF, 64'hFEDCBA9876543210}, 1, 1);
      end
    drain();
    // R5 reserved size, R4 single-bit corruptions, R9 trap and priority
    step(1, mk(0, 2'b11, 5'd1, 5'd1, 5'd1), '1, '1, 1, 1);
    for (int b = 0; b < 32; b++) begin
      logic [31:0] w = mk(1, 2'b01, 5'd2, 5'd3, 5'd4);
      if (!(b == 30 || (b >= 22 && b <= 23) || (b >= 16 && b <= 20) || b <= 9))
        step(1, w ^ (32'd1 << b), '1, '1, 1, 1);
    end
    step(1, mk(0, 2'b00, 5'd10, 5'd11, 5'd12), '1, '1, 0, 1);
    step(1, mk(1, 2'b11, 5'd10, 5'd11, 5'd12), '1, '1, 0, 1);
    drain();
    // random stream with back-pressure (R2, R3)
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w = mk($urandom_range(0,1), 2'($urandom_range(0,2)),
                          5'($urandom), 5'($urandom), 5'($urandom));
      if ($urandom_range(0,15) == 0) w = $urandom;
      step($urandom_range(0,3) != 0, w, {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, $urandom_range(0,15) != 0,
           $urandom_range(0,9) < 7);
    end
    drain();
    chk(q_res.size() == 0, "R3", 128'(q_res.size()), 128'(0));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule